// File: doc/BRIEF.md
# DMA Burst Boundary Splitter

This block sits in front of a single-address DMA transfer engine. It takes one transfer request and breaks it into a series of burst commands. A request carries a byte start address, a total length counted in double words (8 bytes each), a burst size code and a splitting policy. Each burst command gives a byte address, a length in double words and a flag that tells the bus side to keep ownership after the burst. Commands leave through a valid/ready handshake. No burst crosses a 256-byte (32-double-word) address boundary.

There are two policies. The aligning policy first issues a short burst that brings the address up to a multiple of the burst size. After that, every burst has the full configured size. The keep-size policy issues bursts of the configured size straight from the start address. When one of those bursts would straddle a boundary, it is cut in two at the boundary, and the first piece is flagged so the bus stays owned until the second piece has been issued. In either policy, the final burst is trimmed to whatever length is left. A one-cycle completion pulse marks the end of every request, including an empty one.

Top module: `dbs_burst_splitter`

## Requirements
- R1: No burst command covers double words on both sides of a 32-double-word (256-byte) address boundary.
- R2: With `req_mode`=0 and an unaligned start, the first burst ends at the next multiple of the burst size, and every later burst has the full size (e.g. start 0xA8, size 4: 3 double words, then 4 each from 0xC0).
- R3: With `req_mode`=1, bursts of the configured size begin at the start address without alignment. A burst that would cross a boundary is issued as two pieces split at that boundary (e.g. start 0xA8, size 4: the burst at 0xE8 becomes 3 double words, then 1 double word at 0x100).
- R4: `cmd_hold` is 1 on the first piece of a boundary split and 0 on every other command, including a burst that ends exactly at a boundary because the request ends there.
- R5: When fewer double words remain than the computed burst length, the burst is shortened to the remaining count.
- R6: `req_size` code k selects a burst size of 2^k double words, for k = 0 to 3 (1, 2, 4, 8).
- R7: Bits [2:0] of `req_addr` are ignored. Every `cmd_addr` has bits [2:0] equal to zero, and the burst sequence is the same as for the start address with those bits cleared.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_addr`, `cmd_len` and `cmd_hold` stay unchanged and `cmd_valid` stays 1. The sequence advances only on a cycle where both are 1.
- R9: `done` is 1 for exactly one cycle, the cycle after the final burst is accepted. A request with length 0 produces no command and only the `done` pulse, in the cycle after the request is accepted.
- R10: `req_ready` is 1 exactly when no request is in progress, so it is never 1 while `cmd_valid` is 1. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Byte start address (bits [2:0] ignored) |
| req_len | input | LEN_W | Total length in double words |
| req_size | input | SZC_W | Burst size code, size = 2^code double words |
| req_mode | input | 1 | 0 = align first, 1 = keep size and split at boundary |
| cmd_valid | output | 1 | Burst command offered |
| cmd_ready | input | 1 | Engine accepts the burst command |
| cmd_addr | output | ADDR_W | Byte address of the burst |
| cmd_len | output | BL_W | Burst length in double words |
| cmd_hold | output | 1 | Keep bus ownership after this burst |
| done | output | 1 | One-cycle pulse at the end of a request |

## Verification
On every cycle the assertions check that no command crosses a boundary, that a command's length is non-zero and no larger than the maximum size, and that a command stays stable while it is stalled. They also check that a flagged command is always followed by a command starting exactly on a boundary, that `done` never lasts two cycles, and that `req_ready` and `cmd_valid` are never both high. Only the bench scenarios can show that the exact burst sequence matches each policy: the alignment step, the 3+1 split with its flag, the trimmed final burst, the handling of each size code and of the ignored low address bits, and the timing of `done` for empty and non-empty requests. The bench compares every issued command against a reference that walks the request one double word at a time.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   // splitting policy selected per request
   typedef enum logic {
      POL_ALIGN = 1'b0,
      POL_KEEP  = 1'b1
   } dbs_policy_e;

   // bytes per double word, as a shift
   localparam int DW_SHIFT = 3;

endpackage

// File: rtl/dbs_len_calc.sv
module dbs_len_calc #(
   parameter int LEN_W    = 16,
   parameter int BL_W     = 4,
   parameter int OFF_W    = 5,
   parameter int SZC_W    = 2,
   parameter int NSIZES   = 4,
   parameter int BOUND_DW = 32
) (
   input  logic [OFF_W-1:0] off,
   input  logic [LEN_W-1:0] remaining,
   input  logic [BL_W-1:0]  chunk_left,
   input  logic [SZC_W-1:0] size_code,
   input  dbs_pkg::dbs_policy_e policy,
   output logic [BL_W-1:0]  blen,
   output logic             hold
);
   import dbs_pkg::*;

   logic [LEN_W-1:0] size_tab [NSIZES];
   logic [LEN_W-1:0] size_full;
   logic [LEN_W-1:0] misalign;
   logic [LEN_W-1:0] base;
   logic [LEN_W-1:0] chunk;
   logic [LEN_W-1:0] to_bound;
   logic [LEN_W-1:0] len_w;

   // decoded burst sizes, one entry per supported code
   for (genvar i = 0; i < NSIZES; i++) begin : g_size
      assign size_tab[i] = LEN_W'(1) << i;
   end

   always_comb begin
      size_full = (int'(size_code) < NSIZES) ? size_tab[size_code] : size_tab[NSIZES-1];
      misalign  = LEN_W'(off) & (size_full - LEN_W'(1));
      base      = (policy == POL_KEEP) ? LEN_W'(chunk_left) : (size_full - misalign);
      chunk     = (base < remaining) ? base : remaining;
      to_bound  = LEN_W'(BOUND_DW) - LEN_W'(off);
      len_w     = (chunk < to_bound) ? chunk : to_bound;
      blen      = BL_W'(len_w);
      hold      = (policy == POL_KEEP) && (len_w < chunk);
   end

endmodule

// File: rtl/dbs_track.sv
module dbs_track #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int BL_W   = 4,
   parameter int SZC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [SZC_W-1:0]  req_size,
   input  logic              req_mode,
   input  logic              cmd_fire,
   input  logic [BL_W-1:0]   blen,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LEN_W-1:0]  remaining,
   output logic [BL_W-1:0]   chunk_left,
   output logic [SZC_W-1:0]  size_code,
   output dbs_pkg::dbs_policy_e policy,
   output logic              done
);
   import dbs_pkg::*;

   logic [BL_W-1:0] size_full;
   logic [BL_W-1:0] req_size_full;

   assign size_full     = BL_W'(1) << size_code;
   assign req_size_full = BL_W'(1) << req_size;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cur_addr   <= '0;
         remaining  <= '0;
         chunk_left <= '0;
         size_code  <= '0;
         policy     <= POL_ALIGN;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (req_fire) begin
            cur_addr   <= req_addr & ~ADDR_W'(7);
            remaining  <= req_len;
            size_code  <= req_size;
            policy     <= dbs_policy_e'(req_mode);
            chunk_left <= req_size_full;
            busy       <= (req_len != '0);
            done       <= (req_len == '0);
         end else if (cmd_fire) begin
            cur_addr  <= cur_addr + (ADDR_W'(blen) << DW_SHIFT);
            remaining <= remaining - LEN_W'(blen);
            if (policy == POL_ALIGN || blen == chunk_left)
               chunk_left <= size_full;
            else
               chunk_left <= chunk_left - blen;
            if (remaining == LEN_W'(blen)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dbs_burst_splitter.sv
module dbs_burst_splitter #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int MAX_BURST = 8,
   parameter int BOUND_DW  = 32,
   localparam int NSIZES   = $clog2(MAX_BURST) + 1,
   localparam int SZC_W    = (NSIZES > 1) ? $clog2(NSIZES) : 1,
   localparam int BL_W     = $clog2(MAX_BURST) + 1,
   localparam int OFF_W    = $clog2(BOUND_DW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [SZC_W-1:0]  req_size,
   input  logic              req_mode,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [BL_W-1:0]   cmd_len,
   output logic              cmd_hold,
   output logic              done
);
   import dbs_pkg::*;

   // elaboration-time parameter checks
   if ((MAX_BURST & (MAX_BURST - 1)) != 0 || MAX_BURST < 1) begin : g_bad_max
      $error("MAX_BURST must be a power of two");
   end
   if ((BOUND_DW & (BOUND_DW - 1)) != 0 || BOUND_DW < 2) begin : g_bad_bound
      $error("BOUND_DW must be a power of two of at least 2");
   end
   if (MAX_BURST > BOUND_DW) begin : g_bad_ratio
      $error("MAX_BURST must not exceed BOUND_DW");
   end
   if (LEN_W <= OFF_W || ADDR_W <= OFF_W + DW_SHIFT) begin : g_bad_width
      $error("LEN_W or ADDR_W too narrow for the boundary");
   end

   logic              busy;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  remaining;
   logic [BL_W-1:0]   chunk_left;
   logic [SZC_W-1:0]  size_code;
   dbs_policy_e       policy;
   logic [BL_W-1:0]   blen;
   logic              hold;
   logic              req_fire;
   logic              cmd_fire;

   assign req_ready = !busy;
   assign req_fire  = req_valid && req_ready;
   assign cmd_fire  = busy && cmd_ready;

   dbs_track #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BL_W(BL_W), .SZC_W(SZC_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .req_size  (req_size),
      .req_mode  (req_mode),
      .cmd_fire  (cmd_fire),
      .blen      (blen),
      .busy      (busy),
      .cur_addr  (cur_addr),
      .remaining (remaining),
      .chunk_left(chunk_left),
      .size_code (size_code),
      .policy    (policy),
      .done      (done)
   );

   dbs_len_calc #(
      .LEN_W(LEN_W), .BL_W(BL_W), .OFF_W(OFF_W), .SZC_W(SZC_W),
      .NSIZES(NSIZES), .BOUND_DW(BOUND_DW)
   ) u_calc (
      .off       (cur_addr[OFF_W+DW_SHIFT-1:DW_SHIFT]),
      .remaining (remaining),
      .chunk_left(chunk_left),
      .size_code (size_code),
      .policy    (policy),
      .blen      (blen),
      .hold      (hold)
   );

   assign cmd_valid = busy;
   assign cmd_addr  = cur_addr;
   assign cmd_len   = blen;
   assign cmd_hold  = hold;

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
   parameter int ADDR_W    = 32,
   parameter int MAX_BURST = 8,
   parameter int BOUND_DW  = 32,
   parameter int BL_W      = 4,
   parameter int OFF_W     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [BL_W-1:0]   cmd_len,
   input logic              cmd_hold,
   input logic              done
);
   logic [OFF_W-1:0] off;
   assign off = cmd_addr[OFF_W+2:3];

   // R1
   no_boundary_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (int'(off) + int'(cmd_len)) <= BOUND_DW);

   // R5
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_len != '0) && (int'(cmd_len) <= MAX_BURST));

   // R7
   addr_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_addr[2:0] == 3'b000);

   // R8
   stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr)
                                     && $stable(cmd_len) && $stable(cmd_hold));

   // R4
   hold_then_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_hold) |=> cmd_valid && off == '0);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   ready_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && cmd_valid));

endmodule

bind dbs_burst_splitter dbs_checker #(
   .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .BOUND_DW(BOUND_DW),
   .BL_W(BL_W), .OFF_W(OFF_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_addr (cmd_addr),
   .cmd_len  (cmd_len),
   .cmd_hold (cmd_hold),
   .done     (done)
);

// File: tb/dbs_burst_splitter_test.sv
`timescale 1ns/100ps
module dbs_burst_splitter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic [1:0]  req_size = '0;
   logic        req_mode = 1'b0;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [31:0] cmd_addr;
   logic [3:0]  cmd_len;
   logic        cmd_hold;
   logic        done;

   int checks = 0;
   int failures = 0;
   int exp_a [64];
   int exp_l [64];
   int exp_h [64];
   int n_exp;
   logic [7:0] lfsr = 8'hA5;

   always #2.5 clk = ~clk;

   dbs_burst_splitter uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_mode(req_mode),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_hold(cmd_hold),
      .done(done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // walks the request one double word at a time
   task automatic build_ref(input int addr, input int len, input int code, input int mode);
      int d, rem, sz, cc, st, cnt, h;
      bit stop;
      d = addr >> 3; rem = len; sz = 1 << code; cc = 0; n_exp = 0;
      while (rem > 0) begin
         st = d; cnt = 0; h = 0; stop = 0;
         while (!stop) begin
            d++; cnt++; rem--;
            if (mode != 0) cc++;
            if (mode != 0 && cc == sz) begin cc = 0; stop = 1; end
            else if (rem == 0) stop = 1;
            else if (mode == 0 && (d % sz) == 0) stop = 1;
            else if (mode != 0 && (d % 32) == 0) begin stop = 1; h = 1; end
         end
         exp_a[n_exp] = st * 8; exp_l[n_exp] = cnt; exp_h[n_exp] = h;
         n_exp++;
      end
   endtask

   task automatic run_xfer(input string req, input int addr, input int len,
                           input int code, input int mode, input bit stall);
      int idx, guard, pa, pl, ph;
      bit prev_stall;
      build_ref(addr, len, code, mode);
      @(negedge clk);
      chk("R10", "req_ready idle", int'(req_ready), 1);
      req_valid = 1'b1; req_addr = addr; req_len = len; req_size = code; req_mode = mode;
      @(negedge clk);
      req_valid = 1'b0;
      idx = 0; guard = 0; prev_stall = 0; pa = 0; pl = 0; ph = 0;
      if (n_exp == 0) begin
         chk("R9", "empty done", int'(done), 1);
         chk("R9", "empty no cmd", int'(cmd_valid), 0);
         @(negedge clk);
         chk("R9", "empty done drop", int'(done), 0);
         chk("R9", "empty no cmd later", int'(cmd_valid), 0);
         return;
      end
      while (idx < n_exp && guard < 2000) begin
         guard++;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cmd_ready = stall ? (lfsr[0] & lfsr[2]) : 1'b1;
         if (prev_stall) begin
            chk("R8", "stalled valid", int'(cmd_valid), 1);
            chk("R8", "stalled addr", int'(cmd_addr), pa);
            chk("R8", "stalled len", int'(cmd_len), pl);
            chk("R8", "stalled hold", int'(cmd_hold), ph);
         end
         if (req_ready && cmd_valid) chk("R10", "ready while busy", 1, 0);
         if (done) chk("R9", "early done", 1, 0);
         prev_stall = cmd_valid && !cmd_ready;
         pa = int'(cmd_addr); pl = int'(cmd_len); ph = int'(cmd_hold);
         if (cmd_valid && cmd_ready) begin
            chk(req, $sformatf("addr[%0d]", idx), int'(cmd_addr), exp_a[idx]);
            chk(req, $sformatf("len[%0d]", idx), int'(cmd_len), exp_l[idx]);
            chk("R4", $sformatf("hold[%0d]", idx), int'(cmd_hold), exp_h[idx]);
            idx++;
         end
         @(negedge clk);
      end
      cmd_ready = 1'b0;
      chk(req, "all bursts seen", idx, n_exp);
      chk("R9", "done after last", int'(done), 1);
      chk("R9", "idle after last", int'(cmd_valid), 0);
      @(negedge clk);
      chk("R9", "done one cycle", int'(done), 0);
   endtask

   task automatic t_reset();
      chk("R10", "reset req_ready", int'(req_ready), 1);
      chk("R9", "reset cmd_valid", int'(cmd_valid), 0);
      chk("R9", "reset done", int'(done), 0);
   endtask

   // R2 and R5: align first from 0xA8, size 4, trimmed tail
   task automatic t_align_first();
      run_xfer("R2", 32'h0000_10A8, 16, 2, 0, 1'b0);
      chk("R2", "burst count", n_exp, 5);
      chk("R5", "tail length", exp_l[4], 1);
   endtask

   // R3: keep size, 3+1 split at 0xE8
   task automatic t_keep_split();
      run_xfer("R3", 32'h0000_10A8, 16, 2, 1, 1'b0);
      chk("R3", "split first", exp_l[2], 3);
      chk("R3", "split second addr", exp_a[3], 32'h1100);
   endtask

   // R1 and R8: size 8 across a boundary under backpressure
   task automatic t_stall_cross();
      run_xfer("R1", 32'h0000_20F0, 20, 3, 1, 1'b1);
      run_xfer("R1", 32'h0000_3038, 40, 3, 0, 1'b1);
   endtask

   // R6: every size code
   task automatic t_sizes();
      run_xfer("R6", 32'h0000_0010, 3, 0, 0, 1'b0);
      run_xfer("R6", 32'h0000_0008, 5, 1, 0, 1'b0);
      run_xfer("R6", 32'h0000_0048, 11, 3, 1, 1'b0);
      run_xfer("R6", 32'h0000_00F8, 9, 1, 1, 1'b1);
   endtask

   // R7: low three address bits ignored
   task automatic t_low_bits();
      run_xfer("R7", 32'h0000_10AD, 5, 2, 0, 1'b0);
      chk("R7", "first addr cleared", exp_a[0], 32'h10A8);
   endtask

   // R4 and R5: request ending exactly at a boundary in keep mode
   task automatic t_end_at_bound();
      run_xfer("R5", 32'h0000_00E8, 3, 2, 1, 1'b0);
      chk("R5", "single burst", n_exp, 1);
      chk("R4", "no hold at end", exp_h[0], 0);
   endtask

   // R9: empty request
   task automatic t_empty();
      run_xfer("R9", 32'h0000_0040, 0, 2, 0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_align_first();
      t_keep_split();
      t_stall_cross();
      t_sizes();
      t_low_bits();
      t_end_at_bound();
      t_empty();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule